// File: doc/BRIEF.md
# Reservation Station Bank with Dispatch

This block holds the waiting operations for one functional unit of an out-of-order integer core. Each slot stores an operation code, two operand values, two producer tags naming the stations whose results are still owed, a busy indication and a flag recording that the operation has already been sent to the unit. The issue stage names a free slot and writes a fresh operation into it. The bank watches the shared result bus so that operands still owed are filled in. When the unit can accept work, the bank hands over one slot whose operands are all present.

The same module serves both units. An adder bank has three slots carrying tags 0, 1 and 2, and a multiplier bank has two slots carrying tags 3 and 4. The tag of slot i is `BASE_TAG + i`. A slot is released when the result bus carries its own tag. The all-ones tag value (7 with the default 3-bit tag) means "no producer pending". Choosing which free slot issue writes, register renaming and the execution pipeline all sit outside this block.

Top module: `rsb_bank`

## Requirements
- R1: While reset is active, and in the first cycle after it, every bit of `free_mask` is 1 and `disp_valid` is 0.
- R2: An allocation to a slot whose `free_mask` bit is 1 stores the operation, and that bit reads 0 from the next cycle. An allocation naming a slot whose bit is 0 changes nothing in the bank.
- R3: A slot is never dispatched in the cycle in which it is written by issue. A slot written with no producers pending may dispatch in the following cycle.
- R4: When `bc_valid` is high and `bc_tag` equals a busy slot's pending first or second producer tag, that operand takes `bc_data` and the tag becomes the all-ones "no producer" value.
- R5: A slot is never dispatched in the cycle in which it captures an operand from the result bus. It may dispatch in the following cycle.
- R6: When issue writes a slot in the same cycle as a broadcast whose tag equals one of the written producer tags, the slot takes `bc_data` for that operand instead of the value supplied by issue.
- R7: When several slots are ready, the lowest-indexed slot (lowest tag) is dispatched.
- R8: While `unit_busy` is 1, `disp_valid` is 0 and no slot is marked as sent.
- R9: A slot is dispatched exactly once per allocation. After dispatch it stays busy but is not offered again.
- R10: A broadcast of a busy slot's own tag releases it. Its `free_mask` bit stays 0 during that cycle, so an allocation to the slot in that cycle is ignored. The bit reads 1 from the next cycle.
- R11: `disp_tag` equals `BASE_TAG` plus the index of the dispatched slot, and `disp_op`, `disp_vj`, `disp_vk` carry that slot's stored fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Issue writes a slot this cycle |
| alloc_idx | input | IDX_W | Index of the slot to write |
| alloc_op | input | OP_W | Operation code |
| alloc_vj | input | DATA_W | First operand value |
| alloc_vk | input | DATA_W | Second operand value |
| alloc_qj | input | TAG_W | Producer tag of the first operand, all ones if none |
| alloc_qk | input | TAG_W | Producer tag of the second operand, all ones if none |
| bc_valid | input | 1 | Result bus carries a result |
| bc_tag | input | TAG_W | Tag of the producing station |
| bc_data | input | DATA_W | Result value |
| unit_busy | input | 1 | Functional unit cannot accept an operation |
| disp_valid | output | 1 | An operation is handed to the unit this cycle |
| disp_tag | output | TAG_W | Tag of the dispatched slot |
| disp_op | output | OP_W | Operation code of the dispatched slot |
| disp_vj | output | DATA_W | First operand of the dispatched slot |
| disp_vk | output | DATA_W | Second operand of the dispatched slot |
| free_mask | output | N_ENTRIES | Bit i is 1 when slot i may be allocated |

## Verification
Two sets of events can land in the same cycle. Capture and dispatch can coincide, and so can allocation and either a capture or the release of a slot. The stimulus table broadcasts a tag while another slot is ready, so the bench can confirm that only the already-complete slot is handed over and the capturing slot follows one cycle later with the broadcast value. It also issues a slot whose producer is on the bus in that same cycle and expects the captured value at dispatch. It attempts to reallocate a slot in the cycle its own tag is broadcast and expects the attempt to be dropped, which shows in `free_mask` one cycle later.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

   // Life cycle of one reservation slot
   typedef enum logic [1:0] {
      RS_EMPTY   = 2'd0,  // free for allocation
      RS_PENDING = 2'd1,  // holds an operation not yet sent
      RS_SENT    = 2'd2   // sent to the unit, waiting for its own tag
   } rs_state_e;

   localparam int unsigned RSB_DEF_TAG_W  = 3;
   localparam int unsigned RSB_DEF_DATA_W = 32;
   localparam int unsigned RSB_DEF_OP_W   = 2;

endpackage

// File: rtl/rsb_entry.sv
module rsb_entry
   import rsb_pkg::*;
#(
   parameter int unsigned TAG_W  = RSB_DEF_TAG_W,
   parameter int unsigned DATA_W = RSB_DEF_DATA_W,
   parameter int unsigned OP_W   = RSB_DEF_OP_W,
   parameter int unsigned MY_TAG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [OP_W-1:0]   wr_op,
   input  logic [DATA_W-1:0] wr_vj,
   input  logic [DATA_W-1:0] wr_vk,
   input  logic [TAG_W-1:0]  wr_qj,
   input  logic [TAG_W-1:0]  wr_qk,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_data,
   input  logic              take,
   output logic              busy,
   output logic              ready,
   output logic [OP_W-1:0]   op,
   output logic [DATA_W-1:0] vj,
   output logic [DATA_W-1:0] vk,
   output logic [TAG_W-1:0]  qj,
   output logic [TAG_W-1:0]  qk
);

   localparam logic [TAG_W-1:0] NO_TAG = '1;
   localparam logic [TAG_W-1:0] SELF   = TAG_W'(MY_TAG);

   rs_state_e state_q;

   // true when the bus delivers the value owed under tag q
   function automatic logic snoop(input logic [TAG_W-1:0] q);
      return bc_valid && (q != NO_TAG) && (q == bc_tag);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RS_EMPTY;
         op      <= '0;
         vj      <= '0;
         vk      <= '0;
         qj      <= NO_TAG;
         qk      <= NO_TAG;
      end else begin
         case (state_q)
            RS_EMPTY: begin
               if (wr_en) begin
                  state_q <= RS_PENDING;
                  op      <= wr_op;
                  // operand produced on the bus in the issue cycle
                  if (snoop(wr_qj)) begin
                     vj <= bc_data;
                     qj <= NO_TAG;
                  end else begin
                     vj <= wr_vj;
                     qj <= wr_qj;
                  end
                  if (snoop(wr_qk)) begin
                     vk <= bc_data;
                     qk <= NO_TAG;
                  end else begin
                     vk <= wr_vk;
                     qk <= wr_qk;
                  end
               end
            end
            default: begin
               if (bc_valid && (bc_tag == SELF)) begin
                  state_q <= RS_EMPTY;
                  qj      <= NO_TAG;
                  qk      <= NO_TAG;
               end else begin
                  if (snoop(qj)) begin
                     vj <= bc_data;
                     qj <= NO_TAG;
                  end
                  if (snoop(qk)) begin
                     vk <= bc_data;
                     qk <= NO_TAG;
                  end
                  if (take && (state_q == RS_PENDING)) begin
                     state_q <= RS_SENT;
                  end
               end
            end
         endcase
      end
   end

   // readiness is taken from registered fields only, so a slot written
   // or filled in this cycle cannot be offered before the next one
   assign busy  = (state_q != RS_EMPTY);
   assign ready = (state_q == RS_PENDING) && (qj == NO_TAG) && (qk == NO_TAG);

endmodule

// File: rtl/rsb_pick.sv
module rsb_pick #(
   parameter int unsigned N_REQ = 3
) (
   input  logic [N_REQ-1:0] req,
   output logic [N_REQ-1:0] grant
);

   generate
      if (N_REQ == 1) begin : g_single
         assign grant = req;
      end else begin : g_chain
         always_comb begin
            logic found;
            found = 1'b0;
            grant = '0;
            for (int i = 0; i < int'(N_REQ); i++) begin
               if (req[i] && !found) begin
                  grant[i] = 1'b1;
                  found    = 1'b1;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/rsb_bank.sv
module rsb_bank
   import rsb_pkg::*;
#(
   parameter int unsigned N_ENTRIES = 3,
   parameter int unsigned BASE_TAG  = 0,
   parameter int unsigned TAG_W     = RSB_DEF_TAG_W,
   parameter int unsigned DATA_W    = RSB_DEF_DATA_W,
   parameter int unsigned OP_W      = RSB_DEF_OP_W,
   localparam int unsigned IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 alloc_valid,
   input  logic [IDX_W-1:0]     alloc_idx,
   input  logic [OP_W-1:0]      alloc_op,
   input  logic [DATA_W-1:0]    alloc_vj,
   input  logic [DATA_W-1:0]    alloc_vk,
   input  logic [TAG_W-1:0]     alloc_qj,
   input  logic [TAG_W-1:0]     alloc_qk,
   input  logic                 bc_valid,
   input  logic [TAG_W-1:0]     bc_tag,
   input  logic [DATA_W-1:0]    bc_data,
   input  logic                 unit_busy,
   output logic                 disp_valid,
   output logic [TAG_W-1:0]     disp_tag,
   output logic [OP_W-1:0]      disp_op,
   output logic [DATA_W-1:0]    disp_vj,
   output logic [DATA_W-1:0]    disp_vk,
   output logic [N_ENTRIES-1:0] free_mask
);

   localparam int unsigned NO_TAG_VAL = (1 << TAG_W) - 1;

   // elaboration-time parameter checks
   generate
      if (N_ENTRIES < 1) begin : g_bad_count
         $error("rsb_bank: N_ENTRIES must be at least 1");
      end
      if (BASE_TAG + N_ENTRIES > NO_TAG_VAL) begin : g_bad_tag
         $error("rsb_bank: slot tags collide with the no-producer code");
      end
      if (OP_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("rsb_bank: widths must be positive");
      end
   endgenerate

   logic [N_ENTRIES-1:0] busy_vec;
   logic [N_ENTRIES-1:0] ready_vec;
   logic [N_ENTRIES-1:0] grant_vec;
   logic [N_ENTRIES-1:0] wr_vec;
   logic [N_ENTRIES-1:0] take_vec;
   logic [OP_W-1:0]      ent_op [N_ENTRIES];
   logic [DATA_W-1:0]    ent_vj [N_ENTRIES];
   logic [DATA_W-1:0]    ent_vk [N_ENTRIES];
   logic [N_ENTRIES*TAG_W-1:0] qj_flat;
   logic [N_ENTRIES*TAG_W-1:0] qk_flat;

   generate
      for (genvar g = 0; g < int'(N_ENTRIES); g++) begin : g_slot
         logic [TAG_W-1:0] slot_qj;
         logic [TAG_W-1:0] slot_qk;

         // a request to a slot that is still busy is dropped
         assign wr_vec[g]   = alloc_valid && (alloc_idx == IDX_W'(g)) && !busy_vec[g];
         assign take_vec[g] = grant_vec[g] && !unit_busy;

         rsb_entry #(
            .TAG_W  (TAG_W),
            .DATA_W (DATA_W),
            .OP_W   (OP_W),
            .MY_TAG (BASE_TAG + g)
         ) u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_vec[g]),
            .wr_op    (alloc_op),
            .wr_vj    (alloc_vj),
            .wr_vk    (alloc_vk),
            .wr_qj    (alloc_qj),
            .wr_qk    (alloc_qk),
            .bc_valid (bc_valid),
            .bc_tag   (bc_tag),
            .bc_data  (bc_data),
            .take     (take_vec[g]),
            .busy     (busy_vec[g]),
            .ready    (ready_vec[g]),
            .op       (ent_op[g]),
            .vj       (ent_vj[g]),
            .vk       (ent_vk[g]),
            .qj       (slot_qj),
            .qk       (slot_qk)
         );

         assign qj_flat[g*TAG_W +: TAG_W] = slot_qj;
         assign qk_flat[g*TAG_W +: TAG_W] = slot_qk;
      end
   endgenerate

   rsb_pick #(
      .N_REQ (N_ENTRIES)
   ) u_pick (
      .req   (ready_vec),
      .grant (grant_vec)
   );

   assign disp_valid = (|ready_vec) && !unit_busy;
   assign free_mask  = ~busy_vec;

   always_comb begin
      disp_tag = '0;
      disp_op  = '0;
      disp_vj  = '0;
      disp_vk  = '0;
      for (int i = 0; i < int'(N_ENTRIES); i++) begin
         if (grant_vec[i]) begin
            disp_tag = TAG_W'(BASE_TAG + i);
            disp_op  = ent_op[i];
            disp_vj  = ent_vj[i];
            disp_vk  = ent_vk[i];
         end
      end
   end

endmodule

// File: rtl/rsb_bank_chk.sv
module rsb_bank_chk #(
   parameter int unsigned N_ENTRIES = 3,
   parameter int unsigned BASE_TAG  = 0,
   parameter int unsigned TAG_W     = 3,
   parameter int unsigned IDX_W     = 2
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       alloc_valid,
   input logic [IDX_W-1:0]           alloc_idx,
   input logic                       bc_valid,
   input logic [TAG_W-1:0]           bc_tag,
   input logic                       unit_busy,
   input logic                       disp_valid,
   input logic [TAG_W-1:0]           disp_tag,
   input logic [N_ENTRIES-1:0]       free_mask,
   input logic [N_ENTRIES-1:0]       ready_vec,
   input logic [N_ENTRIES*TAG_W-1:0] qj_flat,
   input logic [N_ENTRIES*TAG_W-1:0] qk_flat
);

   localparam logic [TAG_W-1:0] NO_TAG = '1;
   localparam logic [TAG_W-1:0] LO_TAG = TAG_W'(BASE_TAG);
   localparam logic [TAG_W-1:0] HI_TAG = TAG_W'(BASE_TAG + N_ENTRIES - 1);

   // R8
   unit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unit_busy |-> !disp_valid);

   // R11
   tag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |-> (disp_tag >= LO_TAG) && (disp_tag <= HI_TAG));

   generate
      for (genvar g = 0; g < int'(N_ENTRIES); g++) begin : g_per
         localparam logic [TAG_W-1:0] ME = TAG_W'(BASE_TAG + g);
         wire [TAG_W-1:0] my_qj = qj_flat[g*TAG_W +: TAG_W];
         wire [TAG_W-1:0] my_qk = qk_flat[g*TAG_W +: TAG_W];

         // R2
         alloc_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            alloc_valid && (alloc_idx == IDX_W'(g)) && free_mask[g] |=> !free_mask[g]);

         // R3
         issue_nodisp_chk: assert property (@(posedge clk) disable iff (!rst_n)
            alloc_valid && (alloc_idx == IDX_W'(g)) && free_mask[g]
            |-> !(disp_valid && disp_tag == ME));

         // R5
         capture_nodisp_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bc_valid && !free_mask[g] && (bc_tag != NO_TAG)
            && ((my_qj == bc_tag) || (my_qk == bc_tag))
            |-> !(disp_valid && disp_tag == ME));

         // R7
         low_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ready_vec[g] && !unit_busy |-> disp_valid && (disp_tag <= ME));

         // R9
         send_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
            disp_valid && (disp_tag == ME) |=> !(disp_valid && disp_tag == ME));

         // R10
         release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bc_valid && (bc_tag == ME) && !free_mask[g] |=> free_mask[g]);
      end
   endgenerate

endmodule

bind rsb_bank rsb_bank_chk #(
   .N_ENTRIES (N_ENTRIES),
   .BASE_TAG  (BASE_TAG),
   .TAG_W     (TAG_W),
   .IDX_W     (IDX_W)
) u_rsb_bank_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .alloc_valid (alloc_valid),
   .alloc_idx   (alloc_idx),
   .bc_valid    (bc_valid),
   .bc_tag      (bc_tag),
   .unit_busy   (unit_busy),
   .disp_valid  (disp_valid),
   .disp_tag    (disp_tag),
   .free_mask   (free_mask),
   .ready_vec   (ready_vec),
   .qj_flat     (qj_flat),
   .qk_flat     (qk_flat)
);

// File: tb/test_rsb_bank.sv
module test_rsb_bank;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   // adder bank, default parameters
   logic        alloc_valid;
   logic [1:0]  alloc_idx;
   logic [1:0]  alloc_op;
   logic [31:0] alloc_vj, alloc_vk;
   logic [2:0]  alloc_qj, alloc_qk;
   logic        bc_valid;
   logic [2:0]  bc_tag;
   logic [31:0] bc_data;
   logic        unit_busy;
   logic        disp_valid;
   logic [2:0]  disp_tag;
   logic [1:0]  disp_op;
   logic [31:0] disp_vj, disp_vk;
   logic [2:0]  free_mask;

   rsb_bank i_rsb_bank (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_idx(alloc_idx), .alloc_op(alloc_op),
      .alloc_vj(alloc_vj), .alloc_vk(alloc_vk), .alloc_qj(alloc_qj), .alloc_qk(alloc_qk),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data), .unit_busy(unit_busy),
      .disp_valid(disp_valid), .disp_tag(disp_tag), .disp_op(disp_op),
      .disp_vj(disp_vj), .disp_vk(disp_vk), .free_mask(free_mask)
   );

   // multiplier bank: two slots tagged 3 and 4
   logic        m_alloc_valid;
   logic [0:0]  m_alloc_idx;
   logic [31:0] m_alloc_vj, m_alloc_vk;
   logic        m_disp_valid;
   logic [2:0]  m_disp_tag;
   logic [1:0]  m_disp_op;
   logic [31:0] m_disp_vj, m_disp_vk;
   logic [1:0]  m_free_mask;

   rsb_bank #(.N_ENTRIES(2), .BASE_TAG(3)) i_rsb_bank_mul (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(m_alloc_valid), .alloc_idx(m_alloc_idx), .alloc_op(2'd2),
      .alloc_vj(m_alloc_vj), .alloc_vk(m_alloc_vk), .alloc_qj(3'd7), .alloc_qk(3'd7),
      .bc_valid(1'b0), .bc_tag(3'd0), .bc_data(32'd0), .unit_busy(1'b0),
      .disp_valid(m_disp_valid), .disp_tag(m_disp_tag), .disp_op(m_disp_op),
      .disp_vj(m_disp_vj), .disp_vk(m_disp_vk), .free_mask(m_free_mask)
   );

   typedef struct packed {
      logic       av;  logic [1:0] ai;  logic [1:0] aop;
      logic [7:0] avj; logic [7:0] avk; logic [2:0] aqj; logic [2:0] aqk;
      logic       bv;  logic [2:0] bt;  logic [7:0] bd;  logic ub;
      logic       edv; logic [2:0] et;  logic [7:0] evj; logic [7:0] evk;
      logic [2:0] efr;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VECS [NV] = '{
      // c0 idle after reset (R1)
      '{1'b0,2'd0,2'd0,8'd0, 8'd0, 3'd7,3'd7, 1'b0,3'd0,8'd0, 1'b0, 1'b0,3'd0,8'd0, 8'd0, 3'b111},
      // c1 issue slot0 ready; no dispatch in issue cycle (R3, R2)
      '{1'b1,2'd0,2'd1,8'd10,8'd20,3'd7,3'd7, 1'b0,3'd0,8'd0, 1'b0, 1'b0,3'd0,8'd0, 8'd0, 3'b111},
      // c2 slot0 dispatches (R3, R11); issue slot1 waiting on tag 4
      '{1'b1,2'd1,2'd0,8'd0, 8'd5, 3'd4,3'd7, 1'b0,3'd0,8'd0, 1'b0, 1'b1,3'd0,8'd10,8'd20,3'b110},
      // c3 issue slot2 ready, unit busy (R8)
      '{1'b1,2'd2,2'd2,8'd1, 8'd2, 3'd7,3'd7, 1'b0,3'd0,8'd0, 1'b1, 1'b0,3'd0,8'd0, 8'd0, 3'b100},
      // c4 slot1 captures 77 while slot2 dispatches (R5)
      '{1'b0,2'd0,2'd0,8'd0, 8'd0, 3'd7,3'd7, 1'b1,3'd4,8'd77,1'b0, 1'b1,3'd2,8'd1, 8'd2, 3'b000},
      // c5 slot1 dispatches with captured value (R4)
      '{1'b0,2'd0,2'd0,8'd0, 8'd0, 3'd7,3'd7, 1'b0,3'd0,8'd0, 1'b0, 1'b1,3'd1,8'd77,8'd5, 3'b000},
      // c6 own tag 0 frees slot0; realloc in same cycle dropped (R10)
      '{1'b1,2'd0,2'd3,8'd99,8'd99,3'd7,3'd7, 1'b1,3'd0,8'd30,1'b0, 1'b0,3'd0,8'd0, 8'd0, 3'b000},
      // c7 slot0 shows free now and was not rewritten (R10, R2)
      '{1'b0,2'd0,2'd0,8'd0, 8'd0, 3'd7,3'd7, 1'b0,3'd0,8'd0, 1'b0, 1'b0,3'd0,8'd0, 8'd0, 3'b001},
      // c8 issue slot0 waiting 1,2 while tag1 broadcasts 50 (R6)
      '{1'b1,2'd0,2'd3,8'd0, 8'd0, 3'd1,3'd2, 1'b1,3'd1,8'd50,1'b0, 1'b0,3'd0,8'd0, 8'd0, 3'b001},
      // c9 tag2 broadcasts 60: slot0 captures, no dispatch (R5)
      '{1'b0,2'd0,2'd0,8'd0, 8'd0, 3'd7,3'd7, 1'b1,3'd2,8'd60,1'b0, 1'b0,3'd0,8'd0, 8'd0, 3'b010},
      // c10 slot0 dispatches 50,60 (R6, R4)
      '{1'b0,2'd0,2'd0,8'd0, 8'd0, 3'd7,3'd7, 1'b0,3'd0,8'd0, 1'b0, 1'b1,3'd0,8'd50,8'd60,3'b110},
      // c11 no second dispatch (R9)
      '{1'b0,2'd0,2'd0,8'd0, 8'd0, 3'd7,3'd7, 1'b0,3'd0,8'd0, 1'b0, 1'b0,3'd0,8'd0, 8'd0, 3'b110},
      // c12 issue slot1 ready (R3)
      '{1'b1,2'd1,2'd0,8'd3, 8'd4, 3'd7,3'd7, 1'b0,3'd0,8'd0, 1'b0, 1'b0,3'd0,8'd0, 8'd0, 3'b110},
      // c13 issue slot2 ready, unit busy (R8)
      '{1'b1,2'd2,2'd1,8'd5, 8'd6, 3'd7,3'd7, 1'b0,3'd0,8'd0, 1'b1, 1'b0,3'd0,8'd0, 8'd0, 3'b100},
      // c14 unit still busy (R8)
      '{1'b0,2'd0,2'd0,8'd0, 8'd0, 3'd7,3'd7, 1'b0,3'd0,8'd0, 1'b1, 1'b0,3'd0,8'd0, 8'd0, 3'b000},
      // c15 slots 1 and 2 ready, slot1 wins (R7)
      '{1'b0,2'd0,2'd0,8'd0, 8'd0, 3'd7,3'd7, 1'b0,3'd0,8'd0, 1'b0, 1'b1,3'd1,8'd3, 8'd4, 3'b000},
      // c16 then slot2 (R7)
      '{1'b0,2'd0,2'd0,8'd0, 8'd0, 3'd7,3'd7, 1'b0,3'd0,8'd0, 1'b0, 1'b1,3'd2,8'd5, 8'd6, 3'b000},
      // c17 own tag 0 releases slot0 (R10)
      '{1'b0,2'd0,2'd0,8'd0, 8'd0, 3'd7,3'd7, 1'b1,3'd0,8'd0, 1'b0, 1'b0,3'd0,8'd0, 8'd0, 3'b000},
      // c18 slot0 free (R10)
      '{1'b0,2'd0,2'd0,8'd0, 8'd0, 3'd7,3'd7, 1'b0,3'd0,8'd0, 1'b0, 1'b0,3'd0,8'd0, 8'd0, 3'b001}
   };

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      alloc_valid = 1'b0; alloc_idx = '0; alloc_op = '0;
      alloc_vj = '0; alloc_vk = '0; alloc_qj = 3'd7; alloc_qk = 3'd7;
      bc_valid = 1'b0; bc_tag = '0; bc_data = '0; unit_busy = 1'b0;
      m_alloc_valid = 1'b0; m_alloc_idx = '0; m_alloc_vj = '0; m_alloc_vk = '0;
   endtask

   initial begin
      #2000000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      idle_inputs();
      #1;
      // R1: outputs while held in reset
      chk(free_mask == 3'b111, "R1", free_mask, 7);
      chk(disp_valid == 1'b0, "R1", disp_valid, 0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      foreach (VECS[k]) begin
         @(negedge clk);
         alloc_valid = VECS[k].av;  alloc_idx = VECS[k].ai;  alloc_op = VECS[k].aop;
         alloc_vj = 32'(VECS[k].avj); alloc_vk = 32'(VECS[k].avk);
         alloc_qj = VECS[k].aqj;    alloc_qk = VECS[k].aqk;
         bc_valid = VECS[k].bv;     bc_tag = VECS[k].bt;  bc_data = 32'(VECS[k].bd);
         unit_busy = VECS[k].ub;
         #1;
         chk(disp_valid == VECS[k].edv, $sformatf("R3/R5/R7/R8/R9 valid c%0d", k),
             disp_valid, VECS[k].edv);
         if (VECS[k].edv) begin
            chk(disp_tag == VECS[k].et, $sformatf("R7/R11 tag c%0d", k), disp_tag, VECS[k].et);
            chk(disp_vj == 32'(VECS[k].evj), $sformatf("R4/R6/R11 vj c%0d", k),
                disp_vj, VECS[k].evj);
            chk(disp_vk == 32'(VECS[k].evk), $sformatf("R4/R6/R11 vk c%0d", k),
                disp_vk, VECS[k].evk);
         end
         chk(free_mask == VECS[k].efr, $sformatf("R2/R10 free c%0d", k),
             free_mask, VECS[k].efr);
      end

      // R11: multiplier bank tags 3 and 4, fields carried through
      @(negedge clk);
      idle_inputs();
      m_alloc_valid = 1'b1; m_alloc_idx = 1'b1; m_alloc_vj = 32'd9; m_alloc_vk = 32'd2;
      #1;
      chk(m_disp_valid == 1'b0, "R3 mul issue cycle", m_disp_valid, 0);
      @(negedge clk);
      m_alloc_idx = 1'b0; m_alloc_vj = 32'd4; m_alloc_vk = 32'd8;
      #1;
      chk(m_disp_valid && m_disp_tag == 3'd4, "R11 mul tag4", m_disp_tag, 4);
      chk(m_disp_vj == 32'd9 && m_disp_op == 2'd2, "R11 mul fields", m_disp_vj, 9);
      @(negedge clk);
      m_alloc_valid = 1'b0;
      #1;
      chk(m_disp_valid && m_disp_tag == 3'd3, "R11 mul tag3", m_disp_tag, 3);
      chk(m_disp_vk == 32'd8, "R11 mul vk", m_disp_vk, 8);
      chk(m_free_mask == 2'b00, "R2 mul both busy", m_free_mask, 0);

      // R1: reset in mid-run clears both banks
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(free_mask == 3'b111, "R1 mid-run", free_mask, 7);
      chk(m_free_mask == 2'b11, "R1 mid-run mul", m_free_mask, 3);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(disp_valid == 1'b0 && m_disp_valid == 1'b0, "R1 after reset",
          disp_valid | m_disp_valid, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule